// File: doc/BRIEF.md
# Dual-Processor Peripheral Clock Gating Controller

This block decides, every cycle, which clocks in a two-processor subsystem may run. Each processor reports its operating mode (run, sleep or stop) and drives two bit vectors with one bit per peripheral. The first vector claims peripherals for that processor. The second keeps a claimed peripheral clocked while the processor sleeps. From these inputs the block produces a registered clock enable for each processor core, for each peripheral's bus clock, for each peripheral's kernel clock and for each bus matrix. It also produces a request telling the power logic that the whole system may stop.

A peripheral's clock follows the modes of the processors that have claimed it. One claiming processor is enough to keep it clocked. A small set of always-on system peripherals, chosen by a parameter mask, counts as claimed by both processors, with sleep retention, whatever the vectors say. Each peripheral also has a kernel source selector. When the system stops, a claimed peripheral keeps its kernel clock only if that selector names one of the three stop-capable sources. The clock-gate cells are outside the block, which drives only their enables. Each kernel enable is registered on the kernel clock it controls.

Top module: `pcg_top`

## Requirements
- R1: While rst_n is low, every enable output and sys_stop are 0.
- R2: A processor's core clock enable is 1 only when its mode is run (2'b00). Sleep (2'b01), stop (2'b10) and the reserved code 2'b11 give 0, and 2'b11 is treated as stop everywhere.
- R3: A peripheral's bus clock enable is 1 exactly when some processor has its enable bit set for that peripheral and that processor is either in run, or in sleep with its sleep-enable bit set for it. Both processors may claim the same peripheral.
- R4: Peripherals in the ALWAYS_ON mask (default bit 0) behave as if both processors had their enable and sleep-enable bits set, regardless of the input vectors.
- R5: Bus matrix m is enabled exactly when an attached processor (MTX_CPU_MAP) has its core clock enabled or an attached peripheral (MTX_PER_MAP) has its bus clock enabled. The defaults attach processor 0 and peripherals 1..3 to matrix 0, processor 1 and peripherals 4..5 to matrix 1, and both processors and peripherals 0, 6 and 7 to matrix 2.
- R6: sys_stop is 1 exactly when both processors are in stop (2'b10 or 2'b11).
- R7: During system stop every bus enable is 0. A kernel enable is 1 exactly when the peripheral is claimed by either processor (or is always-on) and its 3-bit kernel source is 1, 2 or 3. Sources 0, 4 and 5 give 0. Peripheral p's source is field ker_src_i[3p+2:3p].
- R8: Outside system stop, each kernel enable equals the bus enable of the same peripheral.
- R9: Every output is registered. It shows the inputs sampled at the previous rising edge of its own clock and does not change between edges. A kernel enable is registered on its own ker_clk_i bit.
- R10: A processor that goes to stop and returns, with unchanged vectors, gets back exactly the enables it had before. Mode changes never alter the stored vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock for the core, bus and matrix enables |
| rst_n | input | 1 | Active-low asynchronous reset |
| ker_clk_i | input | NP | Source clock of each peripheral's kernel clock |
| cpu0_mode_i | input | 2 | Processor 0 mode: 00 run, 01 sleep, 10/11 stop |
| cpu1_mode_i | input | 2 | Processor 1 mode, same encoding |
| cpu0_en_i | input | NP | Processor 0 claim bits, one per peripheral |
| cpu0_slp_i | input | NP | Processor 0 sleep-retention bits |
| cpu1_en_i | input | NP | Processor 1 claim bits |
| cpu1_slp_i | input | NP | Processor 1 sleep-retention bits |
| ker_src_i | input | 3*NP | Kernel source per peripheral, 3 bits each |
| cpu_clk_en_o | output | 2 | Core clock enable, bit c for processor c |
| bus_clk_en_o | output | NP | Peripheral bus clock enables |
| ker_clk_en_o | output | NP | Peripheral kernel clock enables |
| mtx_clk_en_o | output | N_MTX | Bus matrix clock enables |
| sys_stop_o | output | 1 | System stop request |

## Verification
The case hardest to reach from the ports is a peripheral claimed by both processors while they sit in different low-power states. One processor sleeps without retention, and the other either retains the peripheral or does not claim it at all. The vector table steps through these mixed pairings, including a sleeping processor whose retention bit is set for a peripheral it never claimed. Another hard case is the system-stop window where only the kernel source decides the outcome. To reach it, both processors are parked in stop, one of them through the reserved mode code, and a kernel selector is changed while the mode inputs are held. A final directed sequence stops and wakes one processor and compares the restored enables with those seen before the stop.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_STOP  = 2'b10,
        MODE_RSVD  = 2'b11
    } cpu_mode_e;

    localparam int KSRC_W = 3;

    localparam logic [KSRC_W-1:0] KSRC_SYS   = 3'd0;
    localparam logic [KSRC_W-1:0] KSRC_HIRC  = 3'd1;
    localparam logic [KSRC_W-1:0] KSRC_LIRC  = 3'd2;
    localparam logic [KSRC_W-1:0] KSRC_LXTAL = 3'd3;
    localparam logic [KSRC_W-1:0] KSRC_PLL   = 3'd4;
    localparam logic [KSRC_W-1:0] KSRC_MRC   = 3'd5;

    // Sources that keep oscillating while the system is stopped.
    function automatic logic ksrc_stop_ok(input logic [KSRC_W-1:0] src);
        return (src == KSRC_HIRC) || (src == KSRC_LIRC) || (src == KSRC_LXTAL);
    endfunction

    // Reserved code behaves as stop.
    function automatic logic mode_is_run(input cpu_mode_e m);
        return m == MODE_RUN;
    endfunction

    function automatic logic mode_is_sleep(input cpu_mode_e m);
        return m == MODE_SLEEP;
    endfunction

    function automatic logic mode_is_stop(input cpu_mode_e m);
        return (m == MODE_STOP) || (m == MODE_RSVD);
    endfunction

endpackage

// File: rtl/pcg_periph_eval.sv
module pcg_periph_eval
    import pcg_pkg::*;
#(
    parameter int NCPU = 2
) (
    input  logic [NCPU-1:0]   en_i,
    input  logic [NCPU-1:0]   slp_i,
    input  logic [NCPU-1:0]   cpu_run_i,
    input  logic [NCPU-1:0]   cpu_sleep_i,
    input  logic              sys_stop_i,
    input  logic [KSRC_W-1:0] src_i,
    output logic              bus_on_o,
    output logic              ker_on_o
);

    logic keep_d;
    logic claimed_d;

    always_comb begin
        keep_d    = 1'b0;
        claimed_d = 1'b0;
        for (int c = 0; c < NCPU; c++) begin
            claimed_d = claimed_d | en_i[c];
            keep_d    = keep_d | (en_i[c] & (cpu_run_i[c] | (cpu_sleep_i[c] & slp_i[c])));
        end
        bus_on_o = keep_d;
        if (sys_stop_i) begin
            ker_on_o = claimed_d & ksrc_stop_ok(src_i);
        end else begin
            ker_on_o = keep_d;
        end
    end

    // R7: in system stop no claimer runs, so no bus clock may be kept
    always_comb begin
        if (sys_stop_i) begin
            a_stop_no_bus_r7: assert (!bus_on_o);
        end
        if (ker_on_o && !bus_on_o) begin
            a_ker_alone_r7: assert (sys_stop_i && ksrc_stop_ok(src_i));
        end
    end

endmodule

// File: rtl/pcg_mtx_eval.sv
module pcg_mtx_eval #(
    parameter int NCPU = 2,
    parameter int NP   = 8
) (
    input  logic [NCPU-1:0] cpu_on_i,
    input  logic [NP-1:0]   bus_on_i,
    input  logic [NCPU-1:0] cpu_map_i,
    input  logic [NP-1:0]   per_map_i,
    output logic            mtx_on_o
);

    logic cpu_hit_d;
    logic per_hit_d;

    always_comb begin
        cpu_hit_d = |(cpu_on_i & cpu_map_i);
        per_hit_d = |(bus_on_i & per_map_i);
        mtx_on_o  = cpu_hit_d | per_hit_d;
    end

endmodule

// File: rtl/pcg_ker_reg.sv
module pcg_ker_reg (
    input  logic kclk,
    input  logic rst_n,
    input  logic en_d,
    output logic en_q
);

    // Enable moves only on the edge of the clock it gates.
    always_ff @(posedge kclk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

endmodule

// File: rtl/pcg_top.sv
module pcg_top
    import pcg_pkg::*;
#(
    parameter int                    NP          = 8,
    parameter int                    N_MTX       = 3,
    parameter logic [NP-1:0]         ALWAYS_ON   = 8'h01,
    parameter logic [N_MTX*2-1:0]    MTX_CPU_MAP = 6'b11_10_01,
    parameter logic [N_MTX*NP-1:0]   MTX_PER_MAP = 24'hC1_30_0E
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0]          ker_clk_i,
    input  logic [1:0]             cpu0_mode_i,
    input  logic [1:0]             cpu1_mode_i,
    input  logic [NP-1:0]          cpu0_en_i,
    input  logic [NP-1:0]          cpu0_slp_i,
    input  logic [NP-1:0]          cpu1_en_i,
    input  logic [NP-1:0]          cpu1_slp_i,
    input  logic [NP*KSRC_W-1:0]   ker_src_i,
    output logic [1:0]             cpu_clk_en_o,
    output logic [NP-1:0]          bus_clk_en_o,
    output logic [NP-1:0]          ker_clk_en_o,
    output logic [N_MTX-1:0]       mtx_clk_en_o,
    output logic                   sys_stop_o
);

    localparam int NCPU = 2;

    typedef struct packed {
        logic [NCPU-1:0]  cpu;
        logic [NP-1:0]    bus;
        logic [N_MTX-1:0] mtx;
        logic             stop;
    } gate_st_t;

    gate_st_t st_d, st_q;

    cpu_mode_e       mode_d [NCPU];
    logic [NCPU-1:0] run_d;
    logic [NCPU-1:0] sleep_d;
    logic            stop_all_d;
    logic [NP-1:0]   en_eff_d  [NCPU];
    logic [NP-1:0]   slp_eff_d [NCPU];
    logic [NP-1:0]   bus_on_d;
    logic [NP-1:0]   ker_on_d;
    logic [N_MTX-1:0] mtx_on_d;

    always_comb begin
        mode_d[0] = cpu_mode_e'(cpu0_mode_i);
        mode_d[1] = cpu_mode_e'(cpu1_mode_i);
        en_eff_d[0]  = cpu0_en_i  | ALWAYS_ON;
        en_eff_d[1]  = cpu1_en_i  | ALWAYS_ON;
        slp_eff_d[0] = cpu0_slp_i | ALWAYS_ON;
        slp_eff_d[1] = cpu1_slp_i | ALWAYS_ON;
        stop_all_d = 1'b1;
        for (int c = 0; c < NCPU; c++) begin
            run_d[c]   = mode_is_run(mode_d[c]);
            sleep_d[c] = mode_is_sleep(mode_d[c]);
            stop_all_d = stop_all_d & mode_is_stop(mode_d[c]);
        end
    end

    genvar gp;
    generate
        for (gp = 0; gp < NP; gp++) begin : g_per
            logic [NCPU-1:0] en_v;
            logic [NCPU-1:0] slp_v;
            always_comb begin
                for (int c = 0; c < NCPU; c++) begin
                    en_v[c]  = en_eff_d[c][gp];
                    slp_v[c] = slp_eff_d[c][gp];
                end
            end

            pcg_periph_eval #(.NCPU(NCPU)) u_eval (
                .en_i        (en_v),
                .slp_i       (slp_v),
                .cpu_run_i   (run_d),
                .cpu_sleep_i (sleep_d),
                .sys_stop_i  (stop_all_d),
                .src_i       (ker_src_i[gp*KSRC_W +: KSRC_W]),
                .bus_on_o    (bus_on_d[gp]),
                .ker_on_o    (ker_on_d[gp])
            );

            pcg_ker_reg u_kreg (
                .kclk  (ker_clk_i[gp]),
                .rst_n (rst_n),
                .en_d  (ker_on_d[gp]),
                .en_q  (ker_clk_en_o[gp])
            );
        end
    endgenerate

    genvar gm;
    generate
        for (gm = 0; gm < N_MTX; gm++) begin : g_mtx
            pcg_mtx_eval #(.NCPU(NCPU), .NP(NP)) u_mtx (
                .cpu_on_i  (run_d),
                .bus_on_i  (bus_on_d),
                .cpu_map_i (MTX_CPU_MAP[gm*NCPU +: NCPU]),
                .per_map_i (MTX_PER_MAP[gm*NP +: NP]),
                .mtx_on_o  (mtx_on_d[gm])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.cpu  = run_d;
        st_d.bus  = bus_on_d;
        st_d.mtx  = mtx_on_d;
        st_d.stop = stop_all_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_clk_en_o = st_q.cpu;
    assign bus_clk_en_o = st_q.bus;
    assign mtx_clk_en_o = st_q.mtx;
    assign sys_stop_o   = st_q.stop;

    // R2: a core clock only follows a run mode seen at the previous edge
    p_core_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en_o[0] |-> ($past(cpu0_mode_i) == 2'b00));
    p_core1_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en_o[1] |-> ($past(cpu1_mode_i) == 2'b00));

    // R6: the stop request and any core clock exclude each other
    p_stop_no_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_stop_o |-> (cpu_clk_en_o == '0));

    // R7: no bus clock survives a system stop
    p_stop_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_stop_o |-> (bus_clk_en_o == '0));

    // R9: a stable input set yields stable registered outputs
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cpu0_mode_i) && $stable(cpu1_mode_i) && $stable(cpu0_en_i) &&
         $stable(cpu1_en_i) && $stable(cpu0_slp_i) && $stable(cpu1_slp_i))
        |=> $stable(bus_clk_en_o));

    generate
        for (gp = 0; gp < NP; gp++) begin : g_chk
            // R3: a bus clock needs a claimer at the previous edge
            p_bus_claimed_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_clk_en_o[gp] && !ALWAYS_ON[gp]) |->
                    ($past(cpu0_en_i[gp]) || $past(cpu1_en_i[gp])));
        end
        for (gm = 0; gm < N_MTX; gm++) begin : g_mchk
            // R5: matrix on exactly when something attached is on
            p_mtx_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ((|(cpu_clk_en_o & MTX_CPU_MAP[gm*NCPU +: NCPU])) ||
                 (|(bus_clk_en_o & MTX_PER_MAP[gm*NP +: NP]))) |-> mtx_clk_en_o[gm]);
            p_mtx_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
                mtx_clk_en_o[gm] |->
                ((|(cpu_clk_en_o & MTX_CPU_MAP[gm*NCPU +: NCPU])) ||
                 (|(bus_clk_en_o & MTX_PER_MAP[gm*NP +: NP]))));
        end
    endgenerate

endmodule

// File: tb/pcg_top_test.sv
module pcg_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  m0, m1;
    logic [7:0]  en0, slp0, en1, slp1;
    logic [23:0] ksrc;
    logic [1:0]  cpu_en;
    logic [7:0]  bus_en, ker_en;
    logic [2:0]  mtx_en;
    logic        stop;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pcg_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ker_clk_i    ({8{clk}}),
        .cpu0_mode_i  (m0),
        .cpu1_mode_i  (m1),
        .cpu0_en_i    (en0),
        .cpu0_slp_i   (slp0),
        .cpu1_en_i    (en1),
        .cpu1_slp_i   (slp1),
        .ker_src_i    (ksrc),
        .cpu_clk_en_o (cpu_en),
        .bus_clk_en_o (bus_en),
        .ker_clk_en_o (ker_en),
        .mtx_clk_en_o (mtx_en),
        .sys_stop_o   (stop)
    );

    // sources p7..p0 = 1,0,5,4,3,2,1,0 ; stop-capable at p1,p2,p3,p7
    localparam logic [23:0] KSRC_BASE = {3'd1, 3'd0, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};

    typedef struct packed {
        logic [1:0] m0, m1;
        logic [7:0] en0, slp0, en1, slp1;
        logic [1:0] cpu;
        logic [7:0] bus, ker;
        logic [2:0] mtx;
        logic       stop;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        // R2 R3 R4 R5: cpu0 runs, cpu1 stopped
        '{2'b00, 2'b10, 8'h0E, 8'h00, 8'h30, 8'h00, 2'b01, 8'h0F, 8'h0F, 3'b101, 1'b0},
        // R3: cpu0 sleeps, retention only on p2
        '{2'b01, 2'b10, 8'h0E, 8'h04, 8'h30, 8'h00, 2'b00, 8'h05, 8'h05, 3'b101, 1'b0},
        // R3 R5: cpu1 sleeps, retention on p4
        '{2'b10, 2'b01, 8'h0E, 8'h00, 8'h30, 8'h10, 2'b00, 8'h11, 8'h11, 3'b110, 1'b0},
        // R6 R7: both stopped, kernel by source
        '{2'b10, 2'b10, 8'h0E, 8'h00, 8'hF0, 8'h00, 2'b00, 8'h00, 8'h8E, 3'b000, 1'b1},
        // R2 R6: reserved code counts as stop
        '{2'b11, 2'b10, 8'h02, 8'h00, 8'h00, 8'h00, 2'b00, 8'h00, 8'h02, 3'b000, 1'b1},
        // R3 R5: shared p6 claimed by both, both run
        '{2'b00, 2'b00, 8'h40, 8'h00, 8'h40, 8'h00, 2'b11, 8'h41, 8'h41, 3'b111, 1'b0},
        // R3: shared p6, one sleeper without and one with retention
        '{2'b01, 2'b01, 8'h40, 8'h00, 8'h40, 8'h40, 2'b00, 8'h41, 8'h41, 3'b100, 1'b0},
        // R3 R4: retention without claim is ignored
        '{2'b01, 2'b10, 8'h00, 8'h40, 8'h40, 8'h00, 2'b00, 8'h01, 8'h01, 3'b100, 1'b0},
        // R5 R8: cpu0 claims everything
        '{2'b00, 2'b00, 8'hFF, 8'h00, 8'h00, 8'h00, 2'b11, 8'hFF, 8'hFF, 3'b111, 1'b0},
        // R4 R5: both run, nothing claimed
        '{2'b00, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 2'b11, 8'h01, 8'h01, 3'b111, 1'b0}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        m0 = v.m0; m1 = v.m1;
        en0 = v.en0; slp0 = v.slp0; en1 = v.en1; slp1 = v.slp1;
    endtask

    task automatic check_all(input vec_t v, input string tag);
        check({tag, " R2 cpu"}, 32'(cpu_en), 32'(v.cpu));
        check({tag, " R3/R4 bus"}, 32'(bus_en), 32'(v.bus));
        check({tag, " R7/R8 ker"}, 32'(ker_en), 32'(v.ker));
        check({tag, " R5 mtx"}, 32'(mtx_en), 32'(v.mtx));
        check({tag, " R6 stop"}, 32'(stop), 32'(v.stop));
    endtask

    initial begin
        ksrc = KSRC_BASE;
        drive(VEC[8]);
        // R1: active inputs during reset leave everything low
        repeat (3) @(negedge clk);
        check("R1 cpu", 32'(cpu_en), 0);
        check("R1 bus", 32'(bus_en), 0);
        check("R1 ker", 32'(ker_en), 0);
        check("R1 mtx", 32'(mtx_en), 0);
        check("R1 stop", 32'(stop), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check_all(VEC[i], $sformatf("vec%0d", i));
        end

        // R9: new inputs are not visible before the next rising edge
        drive(VEC[0]);
        @(negedge clk);
        drive(VEC[3]);
        #1;
        check("R9 bus held", 32'(bus_en), 32'(VEC[0].bus));
        check("R9 stop held", 32'(stop), 0);
        @(negedge clk);
        check_all(VEC[3], "R9 after edge");

        // R7: kernel source change alone under system stop, p4 to source 1
        ksrc[14:12] = 3'd1;
        @(negedge clk);
        check("R7 ker src1", 32'(ker_en), 32'h9E);
        ksrc[14:12] = 3'd5;
        @(negedge clk);
        check("R7 ker src5", 32'(ker_en), 32'h8E);
        ksrc = KSRC_BASE;

        // R10: cpu0 stops, system stops, cpu0 wakes with same vectors
        drive(VEC[0]);
        @(negedge clk);
        check_all(VEC[0], "R10 before");
        m0 = 2'b10;
        @(negedge clk);
        check("R10 stopped", 32'(stop), 1);
        check("R10 stopped ker", 32'(ker_en), 32'h0E);
        m0 = 2'b00;
        @(negedge clk);
        check_all(VEC[0], "R10 restored");

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        #1;
        check("R1 async bus", 32'(bus_en), 0);
        check("R1 async cpu", 32'(cpu_en), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule